// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block sits beside an integer datapath and turns each completed operation into a registered word of status flags. On each clock edge where an operation is presented, it takes the two source operands, the operation code and the result that the datapath produced. From these it derives six flags: carry or borrow, even parity, the half-carry out of the low nibble, zero, sign and signed overflow.

The flags are held in a register and shown as a 16-bit word with each flag at a fixed bit. Data-transfer operations, reserved codes and cycles with no valid operation leave the word exactly as it was. Downstream logic can therefore test conditions produced by an earlier arithmetic or logic step, even after several moves have passed through the datapath. The operand width `DATA_W` is a parameter and must be at least 5. The default is 16.

Top module: `status_flag_unit`

## Requirements
- R1: While `rst_n` is low, the flags word reads 0x0002 after a clock edge.
- R2: For ADD (code 0, result = a + b modulo 2^DATA_W), bit 0 is the carry out of the most significant operand bit.
- R3: For SUB (code 1, result = a − b modulo 2^DATA_W), bit 0 is 1 exactly when b is greater than a as unsigned numbers.
- R4: For ADD and SUB, bit 4 is the carry (ADD) or borrow (SUB) from bit 3 into bit 4. For the logic operations, bit 4 is 0.
- R5: Bit 2 is 1 when the low min(8, DATA_W) bits of the result hold an even number of ones, including none. It is 0 when that count is odd.
- R6: For ADD, SUB, AND, OR and XOR, bit 6 is 1 exactly when the result is zero, and bit 7 equals the result's most significant bit.
- R7: Bit 11 is 1 exactly when ADD or SUB, read as two's-complement, gives a value outside the signed range of DATA_W bits.
- R8: For AND (code 2), OR (code 3) and XOR (code 4), bits 0, 4 and 11 become 0.
- R9: MOV (code 5) and the reserved codes 6 and 7 leave the whole flags word unchanged.
- R10: A cycle with `op_valid` low leaves the flags word unchanged, whatever the other inputs are.
- R11: Bit 1 always reads 1. Every bit other than 0, 1, 2, 4, 6, 7 and 11 always reads 0.
- R12: New flags appear on `flags_word` directly after the clock edge that samples the operation. Before that edge, the previous flags are still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 MOV, 6–7 reserved |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| res_in | input | DATA_W | Result produced by the datapath for this operation |
| flags_word | output | 16 | Registered status flags word |

## Verification
A narrow 6-bit copy of the block is driven with every operand pair under all eight operation codes, while `op_valid` is dropped on a fixed subset of pairs. This covers every carry, borrow, nibble-crossing and signed-overflow case. It separates unsigned wrap from signed overflow, and it shows that held flags survive moves, reserved codes and idle cycles. A 16-bit copy receives directed corner patterns: all-ones plus one, the largest positive number plus one, and zero minus one. These check that parity looks only at the low byte and that flags change exactly at the sampling edge.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam int FLAGS_W = 16;

    localparam int POS_CARRY  = 0;
    localparam int POS_ONE    = 1;
    localparam int POS_PARITY = 2;
    localparam int POS_AUX    = 4;
    localparam int POS_ZERO   = 6;
    localparam int POS_SIGN   = 7;
    localparam int POS_OVF    = 11;

    localparam logic [FLAGS_W-1:0] LIVE_MASK =
        (16'h1 << POS_CARRY) | (16'h1 << POS_PARITY) | (16'h1 << POS_AUX) |
        (16'h1 << POS_ZERO)  | (16'h1 << POS_SIGN)   | (16'h1 << POS_OVF);
    localparam logic [FLAGS_W-1:0] FIXED_ONES = 16'h1 << POS_ONE;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MOV  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_kind_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } flag_set_t;

    localparam flag_set_t FLAGS_RESET = '0;

endpackage

// File: rtl/sfu_arith_flags.sv
module sfu_arith_flags #(
    parameter int DATA_W  = 16,
    parameter int NIBBLE  = 4
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] res,
    input  logic              is_sub,
    output logic              carry_out,
    output logic              aux_out,
    output logic              ovf_out
);
    localparam int MSB = DATA_W - 1;

    // carry (or borrow) entering each bit position, recovered from a ^ b ^ r
    logic [DATA_W-1:0] into_bit;
    logic              msb_prop;

    always_comb begin
        into_bit  = opa ^ opb ^ res;
        msb_prop  = opa[MSB] ^ opb[MSB];
        if (is_sub)
            carry_out = (~opa[MSB] & opb[MSB]) | (~msb_prop & into_bit[MSB]);
        else
            carry_out = (opa[MSB] & opb[MSB]) | (msb_prop & into_bit[MSB]);
        aux_out = into_bit[NIBBLE];
        ovf_out = into_bit[MSB] ^ carry_out;
    end

endmodule

// File: rtl/sfu_parity.sv
module sfu_parity #(
    parameter int DATA_W = 16,
    parameter int SPAN   = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              even
);
    localparam int PW = (DATA_W < SPAN) ? DATA_W : SPAN;

    logic [PW:0] chain;
    assign chain[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < PW; i++) begin : g_chain
            assign chain[i+1] = chain[i] ^ value[i];
        end
    endgenerate

    assign even = ~chain[PW];

endmodule

// File: rtl/sfu_pack.sv
module sfu_pack
    import sfu_pkg::*;
(
    input  flag_set_t            flags,
    output logic [FLAGS_W-1:0]   word
);
    always_comb begin
        word             = FIXED_ONES;
        word[POS_CARRY]  = flags.carry;
        word[POS_PARITY] = flags.parity;
        word[POS_AUX]    = flags.aux;
        word[POS_ZERO]   = flags.zero;
        word[POS_SIGN]   = flags.sign;
        word[POS_OVF]    = flags.ovf;
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] res_in,
    output logic [15:0]       flags_word
);
    localparam int MSB = DATA_W - 1;

    flag_set_t flags_d, flags_q;
    op_kind_e  kind;
    logic      ar_carry, ar_aux, ar_ovf, par_even;

    assign kind = op_kind_e'(op_code);

    sfu_arith_flags #(.DATA_W(DATA_W), .NIBBLE(4)) u_arith (
        .opa       (src_a),
        .opb       (src_b),
        .res       (res_in),
        .is_sub    (kind == OP_SUB),
        .carry_out (ar_carry),
        .aux_out   (ar_aux),
        .ovf_out   (ar_ovf)
    );

    sfu_parity #(.DATA_W(DATA_W), .SPAN(8)) u_parity (
        .value (res_in),
        .even  (par_even)
    );

    always_comb begin
        flags_d = flags_q;
        if (op_valid) begin
            case (kind)
                OP_ADD, OP_SUB: begin
                    flags_d.carry  = ar_carry;
                    flags_d.aux    = ar_aux;
                    flags_d.ovf    = ar_ovf;
                    flags_d.parity = par_even;
                    flags_d.zero   = (res_in == '0);
                    flags_d.sign   = res_in[MSB];
                end
                OP_AND, OP_OR, OP_XOR: begin
                    flags_d.carry  = 1'b0;
                    flags_d.aux    = 1'b0;
                    flags_d.ovf    = 1'b0;
                    flags_d.parity = par_even;
                    flags_d.zero   = (res_in == '0);
                    flags_d.sign   = res_in[MSB];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end

    sfu_pack u_pack (
        .flags (flags_q),
        .word  (flags_word)
    );

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
    import sfu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] res_in,
    input logic [15:0]       flags_word
);
    localparam int MSB = DATA_W - 1;

    assert_fixed_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_word & ~LIVE_MASK) == FIXED_ONES);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_word));

    assert_move_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 3'd5) |=> $stable(flags_word));

    assert_logic_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 3'd2 && op_code <= 3'd4) |=>
        (!flags_word[POS_CARRY] && !flags_word[POS_AUX] && !flags_word[POS_OVF]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4) |=>
        (flags_word[POS_ZERO] == ($past(res_in) == '0)));

    assert_sign_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code <= 3'd4) |=>
        (flags_word[POS_SIGN] == $past(res_in[MSB])));

    assert_add_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd0) |=>
        (flags_word[POS_OVF] == ($past(src_a[MSB]) == $past(src_b[MSB]) &&
                                 $past(res_in[MSB]) != $past(src_a[MSB]))));

endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .src_a      (src_a),
    .src_b      (src_b),
    .res_in     (res_in),
    .flags_word (flags_word)
);

// File: tb/test_status_flag_unit.sv
module test_status_flag_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WIDE  = 16;
    localparam int NARROW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic             w_valid = 1'b0;
    logic [2:0]       w_op = '0;
    logic [WIDE-1:0]  w_a = '0, w_b = '0, w_r = '0;
    logic [15:0]      w_flags;

    logic             n_valid = 1'b0;
    logic [2:0]       n_op = '0;
    logic [NARROW-1:0] n_a = '0, n_b = '0, n_r = '0;
    logic [15:0]      n_flags;

    status_flag_unit #(.DATA_W(WIDE)) i_status_flag_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(w_valid), .op_code(w_op),
        .src_a(w_a), .src_b(w_b), .res_in(w_r), .flags_word(w_flags)
    );

    status_flag_unit #(.DATA_W(NARROW)) i_status_flag_unit_narrow (
        .clk(clk), .rst_n(rst_n), .op_valid(n_valid), .op_code(n_op),
        .src_a(n_a), .src_b(n_b), .res_in(n_r), .flags_word(n_flags)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, got, exp);
        end
    endtask

    function automatic int calc_result(int w, int op, int a, int b);
        int mask = (1 << w) - 1;
        case (op)
            0: return (a + b) & mask;
            1: return (a - b) & mask;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return (a * 5 + b) & mask; // arbitrary for hold cases
        endcase
    endfunction

    function automatic logic [15:0] calc_flags(int w, int op, int a, int b, logic [15:0] prev);
        int r = calc_result(w, op, a, b);
        int half = 1 << (w - 1);
        int sa = (a >= half) ? a - (1 << w) : a;
        int sb = (b >= half) ? b - (1 << w) : b;
        int sv, ones, pw;
        logic c = 0, ac = 0, o = 0;
        logic [15:0] word;
        if (op >= 5) return prev;
        if (op == 0) begin
            c  = ((a + b) >> w) & 1;
            ac = (((a & 15) + (b & 15)) >> 4) & 1;
            sv = sa + sb;
            o  = (sv >= half) || (sv < -half);
        end else if (op == 1) begin
            c  = (a < b);
            ac = ((a & 15) < (b & 15));
            sv = sa - sb;
            o  = (sv >= half) || (sv < -half);
        end
        pw = (w < 8) ? w : 8;
        ones = 0;
        for (int i = 0; i < pw; i++) ones += (r >> i) & 1;
        word = 16'h0002;
        word[0]  = c;
        word[2]  = (ones % 2 == 0);
        word[4]  = ac;
        word[6]  = (r == 0);
        word[7]  = (r >> (w - 1)) & 1;
        word[11] = o;
        return word;
    endfunction

    task automatic wide_op(input int op, input int a, input int b, input logic valid);
        @(negedge clk);
        w_valid = valid; w_op = op[2:0]; w_a = a[WIDE-1:0]; w_b = b[WIDE-1:0];
        w_r = calc_result(WIDE, op, a, b);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] prev, held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset wide", w_flags, 16'h0002);
        check("R1 reset narrow", n_flags, 16'h0002);
        @(negedge clk); rst_n = 1'b1;

        // R2 R4 R5 R6: all-ones plus one wraps to zero, low byte even
        wide_op(0, 16'hFFFF, 1, 1'b1);
        check("R2 add wrap", w_flags, 16'h0057);
        // R7: largest positive plus one
        wide_op(0, 16'h7FFF, 1, 1'b1);
        check("R7 add overflow", w_flags, 16'h0896);
        // R9: move keeps word
        wide_op(5, 16'h0000, 16'h0000, 1'b1);
        check("R9 move holds", w_flags, 16'h0896);
        // R10: idle cycle with live operands
        wide_op(0, 16'hFFFF, 1, 1'b0);
        check("R10 idle holds", w_flags, 16'h0896);
        // R3: zero minus one
        wide_op(1, 0, 1, 1'b1);
        check("R3 sub borrow", w_flags, 16'h0097);
        // R5: parity ignores high byte (0x0100 low byte zero -> even)
        wide_op(3, 16'h0100, 16'h0000, 1'b1);
        check("R5 parity low byte", w_flags, calc_flags(WIDE, 3, 16'h0100, 0, 16'h0));
        // R8: logic after overflow clears C/A/O
        wide_op(0, 16'h7FFF, 1, 1'b1);
        wide_op(4, 16'h8001, 16'h0001, 1'b1);
        check("R8 logic clears", w_flags, 16'h0086);
        // R12: inputs presented but edge not yet reached
        @(negedge clk);
        w_valid = 1'b1; w_op = 3'd0; w_a = 16'hFFFF; w_b = 16'h0001; w_r = 16'h0000;
        #1;
        check("R12 before edge", w_flags, 16'h0086);
        @(posedge clk); #1;
        check("R12 after edge", w_flags, 16'h0057);
        check("R11 fixed bits", w_flags & 16'hF728, 16'h0000);
        @(negedge clk); w_valid = 1'b0;

        // Exhaustive narrow sweep: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        prev = 16'h0002;
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < (1 << NARROW); a++) begin
                for (int b = 0; b < (1 << NARROW); b++) begin
                    logic v;
                    @(negedge clk);
                    v = (((a ^ b) & 7) != 7);
                    n_valid = v; n_op = op[2:0];
                    n_a = a[NARROW-1:0]; n_b = b[NARROW-1:0];
                    n_r = calc_result(NARROW, op, a, b);
                    held = v ? calc_flags(NARROW, op, a, b, prev) : prev;
                    @(posedge clk); #1;
                    check(v ? "R2-R9 sweep" : "R10 sweep idle", n_flags, held);
                    prev = held;
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule